// File: doc/BRIEF.md
# Masked Configuration Register Space

This block holds the 256-byte configuration header of one function of a bus device with a Type 0 header. A requester issues single-cycle requests carrying a function number, a byte address, an access size of one, two or four bytes and, for writes, a data word. Every byte of the space has a fixed write mask. A write changes only the masked bits. Identification fields, type bits and capability structures therefore keep the values they were given at reset, while the writable fields take new data.

Identification values, the sizes and kinds of the six base address registers, and the capability structures are parameters. At reset the capabilities are linked into a list whose head pointer sits at offset 0x34. Reads return a response one cycle after the request. The command register and the six base address registers are also driven out as ports. A one-cycle remap pulse tells a downstream address decoder that the window it decodes may have moved.

Top module: `masked_cfg_space`

## Requirements
- R1: After reset the space holds its identity. Offsets 0x00-0x03 hold the vendor and device IDs, 0x08 the revision, 0x09-0x0B the class code, 0x2C-0x2F the subsystem IDs and 0x3D the interrupt pin, with the command register at 0. An implemented I/O base register reads 0x00000001 and every other base register reads 0.
- R2: A write stores each addressed byte as (old & ~mask) | (data & mask). In the command register (offset 0x04) only bits 0 (I/O enable), 1 (memory enable) and 2 (bus master) are writable. The ID and class bytes are read-only.
- R3: Multi-byte data is little-endian. Data byte 0 (bits 7:0) goes to the request address, and each following byte goes to the next address up. Reads assemble bytes in the same order.
- R4: A write that runs past offset 0xFF stores the bytes that fit and drops the rest, with no wrap to offset 0x00.
- R5: Offsets 0x0C and 0x3C are fully writable. Every byte from 0x40 to 0xFF that no capability occupies is also fully writable.
- R6: A base register of size 2^n bytes (n > 0) accepts writes only to bits 31..n. Its low type bits stay fixed: bit 0 = 1 for I/O, bits 3:0 = 0 for memory. A base register with n = 0 is unimplemented and stays 0.
- R7: A read of size code 2 (four bytes) returns a full word only at addresses up to 0xFC. Size code 1 (two bytes) returns a half word only up to 0xFE. Any other read, including size code 0, size code 3 and out-of-range wide reads, returns the single byte at the address, zero-extended.
- R8: A request whose function number differs from the block's own has no effect when it is a write. When it is a read, it returns all ones truncated to the access width: 0xFF, 0xFFFF or 0xFFFFFFFF.
- R9: The remap pulse is high for exactly the cycle after a write, and only when that write changed a byte in 0x10-0x27 or flipped command bit 0 or 1. A write that changes nothing there, or toggles only the bus-master bit, gives no pulse.
- R10: The capability list is built at reset. Offset 0x34 points at the last listed capability. Each capability holds its ID at its first byte and, at the next byte, the offset of the capability listed before it (0 ends the list). Status bit 4 (offset 0x06) is set. Capability bytes are read-only.
- R11: The response valid flag is high exactly in the cycle after a read request, and is low after writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqFunc | input | FUNC_W | Target function number |
| reqAddr | input | 8 | Byte address |
| reqSize | input | 2 | 0 = one byte, 1 = two, 2 = four, 3 = one |
| reqWdata | input | 32 | Write data, lowest byte to lowest address |
| rspValid | output | 1 | Read data valid |
| rspData | output | 32 | Read data |
| remapPulse | output | 1 | Decode window may have moved |
| cmdOut | output | 16 | Current command register |
| barOut | output | 192 | Six base registers, register k in bits 32k+31:32k |

## Verification
The masked write is tried in four ways: all ones over read-only identity bytes, over the command register, over base registers of two sizes and kinds, and over capability bytes. Comparing the results shows which bits each mask lets through. Distinct byte patterns written at aligned and unaligned addresses, and read back at every size, separate correct byte order from swapped or shifted lanes. Writes that cross the top of the space, and wide reads near it, expose wrap and fallback errors. Remap is probed with three kinds of write: ones that change a window, ones that rewrite the same value, and ones that flip only the bus-master bit. Together these separate a compare-based pulse from one that fires on every write. Foreign-function requests show whether the function filter guards both reads and writes.

// File: rtl/mcfg_pkg.sv
package mcfg_pkg;

  localparam int unsigned SPACE_BYTES = 256;
  localparam int unsigned LANES       = 4;
  localparam int unsigned BAR_COUNT   = 6;

  localparam logic [7:0] CMD_LO     = 8'h04;
  localparam logic [7:0] LINE_SIZE  = 8'h0C;
  localparam logic [7:0] BAR_FIRST  = 8'h10;
  localparam logic [7:0] BAR_LAST   = 8'h27;
  localparam logic [7:0] CAP_PTR    = 8'h34;
  localparam logic [7:0] IRQ_LINE   = 8'h3C;
  localparam logic [7:0] DEV_AREA   = 8'h40;

  // read data shaping chosen by control
  typedef enum logic [2:0] {
    RD_BYTE   = 3'd0,
    RD_WORD   = 3'd1,
    RD_DWORD  = 3'd2,
    RD_ONES8  = 3'd3,
    RD_ONES16 = 3'd4,
    RD_ONES32 = 3'd5
  } rdMode_e;

  typedef struct packed {
    logic       rdEn;
    rdMode_e    rdMode;
    logic [3:0] wrLane;
  } mcfgStrobe_t;

endpackage

// File: rtl/mcfg_ctrl.sv
module mcfg_ctrl
  import mcfg_pkg::*;
#(
  parameter int unsigned FUNC_W   = 3,
  parameter int unsigned FUNC_NUM = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [FUNC_W-1:0] reqFunc,
  input  logic [7:0]        reqAddr,
  input  logic [1:0]        reqSize,
  input  logic              dpChange,
  output mcfgStrobe_t       strb,
  output logic              rspValid,
  output logic              remapPulse
);

  localparam logic [FUNC_W-1:0] OWN_FUNC = FUNC_W'(FUNC_NUM);

  logic       funcHit;
  logic [2:0] nBytes;
  logic [3:0] laneEn;
  rdMode_e    rdMode;

  assign funcHit = (reqFunc == OWN_FUNC);

  always_comb begin
    case (reqSize)
      2'd1:    nBytes = 3'd2;
      2'd2:    nBytes = 3'd4;
      default: nBytes = 3'd1;
    endcase
  end

  // a lane writes when it is inside the access and inside the space
  for (genvar g = 0; g < LANES; g++) begin : gLaneEn
    assign laneEn[g] = reqValid && reqWrite && funcHit &&
                       (3'(g) < nBytes) &&
                       (({1'b0, reqAddr} + 9'(g)) <= 9'd255);
  end

  always_comb begin
    if (!funcHit) begin
      case (reqSize)
        2'd1:    rdMode = RD_ONES16;
        2'd2:    rdMode = RD_ONES32;
        default: rdMode = RD_ONES8;
      endcase
    end else if (reqSize == 2'd2 && reqAddr <= 8'hFC) begin
      rdMode = RD_DWORD;
    end else if (reqSize == 2'd1 && reqAddr <= 8'hFE) begin
      rdMode = RD_WORD;
    end else begin
      rdMode = RD_BYTE;
    end
  end

  always_comb begin
    strb.rdEn   = reqValid && !reqWrite;
    strb.rdMode = rdMode;
    strb.wrLane = laneEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid   <= 1'b0;
      remapPulse <= 1'b0;
    end else begin
      rspValid   <= strb.rdEn;
      remapPulse <= (|laneEn) && dpChange;
    end
  end

endmodule

// File: rtl/mcfg_dp.sv
module mcfg_dp
  import mcfg_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID     = 16'h5A17,
  parameter logic [15:0] DEVICE_ID     = 16'h0C3E,
  parameter logic [7:0]  REVISION      = 8'h02,
  parameter logic [23:0] CLASS_CODE    = 24'h020000,
  parameter logic [15:0] SUB_VENDOR_ID = 16'h5A17,
  parameter logic [15:0] SUB_DEVICE_ID = 16'h0001,
  parameter logic [7:0]  INT_PIN       = 8'h01,
  parameter int unsigned BAR_LOG2 [BAR_COUNT] = '{8, 0, 12, 0, 0, 0},
  parameter bit          BAR_IO   [BAR_COUNT] = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
  parameter int unsigned CAP_NUM  = 2,
  parameter logic [7:0]  CAP_OFS [CAP_NUM] = '{8'h40, 8'h50},
  parameter logic [7:0]  CAP_ID  [CAP_NUM] = '{8'h05, 8'h01},
  parameter int unsigned CAP_LEN [CAP_NUM] = '{8, 8}
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  mcfgStrobe_t               strb,
  input  logic [7:0]                reqAddr,
  input  logic [31:0]               reqWdata,
  output logic                      dpChange,
  output logic [31:0]               rspData,
  output logic [15:0]               cmdOut,
  output logic [BAR_COUNT*32-1:0]   barOut
);

  logic [7:0] cfgMem [SPACE_BYTES];

  logic [LANES-1:0][7:0] laneAddr;
  logic [LANES-1:0][7:0] oldByte;
  logic [LANES-1:0][7:0] newByte;
  logic [LANES-1:0][7:0] laneMask;
  logic [LANES-1:0]      laneHit;
  logic [31:0]           rdWord;

  function automatic logic inCap(input logic [7:0] a);
    logic hit;
    hit = 1'b0;
    for (int c = 0; c < int'(CAP_NUM); c++) begin
      if (int'(a) >= int'(CAP_OFS[c]) && int'(a) < int'(CAP_OFS[c]) + int'(CAP_LEN[c]))
        hit = 1'b1;
    end
    return hit;
  endfunction

  function automatic logic [31:0] barMask(input int k);
    logic [31:0] m;
    if (BAR_LOG2[k] == 0) begin
      m = 32'h0;
    end else begin
      m = ~((32'd1 << BAR_LOG2[k]) - 32'd1);
      m = m & (BAR_IO[k] ? 32'hFFFF_FFFC : 32'hFFFF_FFF0);
    end
    return m;
  endfunction

  function automatic logic [7:0] maskOf(input logic [7:0] a);
    logic [7:0]  m;
    logic [31:0] bm;
    m = 8'h00;
    if (a == CMD_LO) begin
      m = 8'h07;
    end else if (a == LINE_SIZE || a == IRQ_LINE) begin
      m = 8'hFF;
    end else if (a >= BAR_FIRST && a <= BAR_LAST) begin
      bm = barMask(int'(a - BAR_FIRST) >> 2);
      m  = bm[8*a[1:0] +: 8];
    end else if (a >= DEV_AREA) begin
      m = inCap(a) ? 8'h00 : 8'hFF;
    end
    return m;
  endfunction

  function automatic logic [7:0] resetOf(input logic [7:0] a);
    logic [7:0] v;
    int         k;
    v = 8'h00;
    case (a)
      8'h00: v = VENDOR_ID[7:0];
      8'h01: v = VENDOR_ID[15:8];
      8'h02: v = DEVICE_ID[7:0];
      8'h03: v = DEVICE_ID[15:8];
      8'h06: v = 8'h10;
      8'h08: v = REVISION;
      8'h09: v = CLASS_CODE[7:0];
      8'h0A: v = CLASS_CODE[15:8];
      8'h0B: v = CLASS_CODE[23:16];
      8'h2C: v = SUB_VENDOR_ID[7:0];
      8'h2D: v = SUB_VENDOR_ID[15:8];
      8'h2E: v = SUB_DEVICE_ID[7:0];
      8'h2F: v = SUB_DEVICE_ID[15:8];
      8'h3D: v = INT_PIN;
      default: v = 8'h00;
    endcase
    if (a == CAP_PTR) v = CAP_OFS[CAP_NUM-1];
    if (a >= BAR_FIRST && a <= BAR_LAST && a[1:0] == 2'b00) begin
      k = int'(a - BAR_FIRST) >> 2;
      if (BAR_LOG2[k] != 0 && BAR_IO[k]) v = 8'h01;
    end
    for (int c = 0; c < int'(CAP_NUM); c++) begin
      if (a == CAP_OFS[c]) v = CAP_ID[c];
      if (int'(a) == int'(CAP_OFS[c]) + 1)
        v = (c == 0) ? 8'h00 : CAP_OFS[(c == 0) ? 0 : c - 1];
    end
    return v;
  endfunction

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign laneAddr[g] = reqAddr + 8'(g);
    assign oldByte[g]  = cfgMem[laneAddr[g]];
    assign laneMask[g] = maskOf(laneAddr[g]);
    assign newByte[g]  = (oldByte[g] & ~laneMask[g]) |
                         (reqWdata[8*g +: 8] & laneMask[g]);
    assign laneHit[g]  = strb.wrLane[g] &&
                         (((laneAddr[g] >= BAR_FIRST) && (laneAddr[g] <= BAR_LAST) &&
                           (newByte[g] != oldByte[g])) ||
                          ((laneAddr[g] == CMD_LO) &&
                           (((newByte[g] ^ oldByte[g]) & 8'h03) != 8'h00)));
  end

  assign dpChange = |laneHit;

  always_comb begin
    case (strb.rdMode)
      RD_DWORD:  rdWord = {oldByte[3], oldByte[2], oldByte[1], oldByte[0]};
      RD_WORD:   rdWord = {16'h0000, oldByte[1], oldByte[0]};
      RD_BYTE:   rdWord = {24'h000000, oldByte[0]};
      RD_ONES8:  rdWord = 32'h0000_00FF;
      RD_ONES16: rdWord = 32'h0000_FFFF;
      RD_ONES32: rdWord = 32'hFFFF_FFFF;
      default:   rdWord = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < int'(SPACE_BYTES); i++) cfgMem[i] <= resetOf(8'(i));
      rspData <= 32'h0;
    end else begin
      for (int g = 0; g < int'(LANES); g++) begin
        if (strb.wrLane[g]) cfgMem[laneAddr[g]] <= newByte[g];
      end
      if (strb.rdEn) rspData <= rdWord;
    end
  end

  assign cmdOut = {cfgMem[5], cfgMem[4]};

  for (genvar b = 0; b < BAR_COUNT; b++) begin : gBar
    localparam int BASE = 16 + 4 * b;
    assign barOut[32*b +: 32] = {cfgMem[BASE+3], cfgMem[BASE+2],
                                 cfgMem[BASE+1], cfgMem[BASE]};
  end

endmodule

// File: rtl/masked_cfg_space.sv
module masked_cfg_space
  import mcfg_pkg::*;
#(
  parameter int unsigned FUNC_W        = 3,
  parameter int unsigned FUNC_NUM      = 0,
  parameter logic [15:0] VENDOR_ID     = 16'h5A17,
  parameter logic [15:0] DEVICE_ID     = 16'h0C3E,
  parameter logic [7:0]  REVISION      = 8'h02,
  parameter logic [23:0] CLASS_CODE    = 24'h020000,
  parameter logic [15:0] SUB_VENDOR_ID = 16'h5A17,
  parameter logic [15:0] SUB_DEVICE_ID = 16'h0001,
  parameter logic [7:0]  INT_PIN       = 8'h01,
  parameter int unsigned BAR_LOG2 [BAR_COUNT] = '{8, 0, 12, 0, 0, 0},
  parameter bit          BAR_IO   [BAR_COUNT] = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
  parameter int unsigned CAP_NUM  = 2,
  parameter logic [7:0]  CAP_OFS [CAP_NUM] = '{8'h40, 8'h50},
  parameter logic [7:0]  CAP_ID  [CAP_NUM] = '{8'h05, 8'h01},
  parameter int unsigned CAP_LEN [CAP_NUM] = '{8, 8}
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic                    reqWrite,
  input  logic [FUNC_W-1:0]       reqFunc,
  input  logic [7:0]              reqAddr,
  input  logic [1:0]              reqSize,
  input  logic [31:0]             reqWdata,
  output logic                    rspValid,
  output logic [31:0]             rspData,
  output logic                    remapPulse,
  output logic [15:0]             cmdOut,
  output logic [BAR_COUNT*32-1:0] barOut
);

  mcfgStrobe_t strb;
  logic        dpChange;

  mcfg_ctrl #(
    .FUNC_W   (FUNC_W),
    .FUNC_NUM (FUNC_NUM)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .reqFunc    (reqFunc),
    .reqAddr    (reqAddr),
    .reqSize    (reqSize),
    .dpChange   (dpChange),
    .strb       (strb),
    .rspValid   (rspValid),
    .remapPulse (remapPulse)
  );

  mcfg_dp #(
    .VENDOR_ID     (VENDOR_ID),
    .DEVICE_ID     (DEVICE_ID),
    .REVISION      (REVISION),
    .CLASS_CODE    (CLASS_CODE),
    .SUB_VENDOR_ID (SUB_VENDOR_ID),
    .SUB_DEVICE_ID (SUB_DEVICE_ID),
    .INT_PIN       (INT_PIN),
    .BAR_LOG2      (BAR_LOG2),
    .BAR_IO        (BAR_IO),
    .CAP_NUM       (CAP_NUM),
    .CAP_OFS       (CAP_OFS),
    .CAP_ID        (CAP_ID),
    .CAP_LEN       (CAP_LEN)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .dpChange (dpChange),
    .rspData  (rspData),
    .cmdOut   (cmdOut),
    .barOut   (barOut)
  );

endmodule

// File: rtl/mcfg_chk.sv
module mcfg_chk
  import mcfg_pkg::*;
#(
  parameter int unsigned FUNC_W   = 3,
  parameter int unsigned FUNC_NUM = 0
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    reqValid,
  input logic                    reqWrite,
  input logic [FUNC_W-1:0]       reqFunc,
  input logic [1:0]              reqSize,
  input logic                    rspValid,
  input logic [31:0]             rspData,
  input logic                    remapPulse,
  input logic [15:0]             cmdOut,
  input logic [BAR_COUNT*32-1:0] barOut
);

  localparam logic [FUNC_W-1:0] OWN_FUNC = FUNC_W'(FUNC_NUM);

  a_r11_rsp_after_read: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite) |=> rspValid);

  a_r11_rsp_only_read: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(reqValid && !reqWrite));

  a_r9_remap_tracks_change: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && reqFunc == OWN_FUNC) |=>
      (remapPulse == ((cmdOut[1:0] != $past(cmdOut[1:0])) || (barOut != $past(barOut)))));

  a_r9_remap_needs_write: assert property (@(posedge clk) disable iff (!rstN)
    remapPulse |-> $past(reqValid && reqWrite));

  a_r8_foreign_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && reqFunc != OWN_FUNC) |=>
      ($stable(cmdOut) && $stable(barOut) && !remapPulse));

  a_r8_foreign_read_ones: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && reqFunc != OWN_FUNC && reqSize == 2'd2) |=>
      (rspData == 32'hFFFF_FFFF));

  a_r2_cmd_upper_fixed: assert property (@(posedge clk) disable iff (!rstN)
    cmdOut[15:3] == 13'd0);

endmodule

bind masked_cfg_space mcfg_chk #(
  .FUNC_W   (FUNC_W),
  .FUNC_NUM (FUNC_NUM)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqWrite   (reqWrite),
  .reqFunc    (reqFunc),
  .reqSize    (reqSize),
  .rspValid   (rspValid),
  .rspData    (rspData),
  .remapPulse (remapPulse),
  .cmdOut     (cmdOut),
  .barOut     (barOut)
);

// File: tb/masked_cfg_space_tb.sv
module masked_cfg_space_tb;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         reqValid = 1'b0;
  logic         reqWrite = 1'b0;
  logic [2:0]   reqFunc = 3'd0;
  logic [7:0]   reqAddr = 8'h00;
  logic [1:0]   reqSize = 2'd0;
  logic [31:0]  reqWdata = 32'h0;
  logic         rspValid;
  logic [31:0]  rspData;
  logic         remapPulse;
  logic [15:0]  cmdOut;
  logic [191:0] barOut;

  int total = 0;
  int failed = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  masked_cfg_space u_dut (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .reqFunc    (reqFunc),
    .reqAddr    (reqAddr),
    .reqSize    (reqSize),
    .reqWdata   (reqWdata),
    .rspValid   (rspValid),
    .rspData    (rspData),
    .remapPulse (remapPulse),
    .cmdOut     (cmdOut),
    .barOut     (barOut)
  );

  typedef struct packed {
    logic        wr;
    logic [2:0]  fn;
    logic [7:0]  addr;
    logic [1:0]  sz;
    logic [31:0] wd;
    logic [31:0] exp;
    logic        remap;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 49;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 3'd0, 8'h00, 2'd2, 32'h0,        32'h0C3E5A17, 1'b0, 8'd1},  // R1 ids
    '{1'b0, 3'd0, 8'h08, 2'd2, 32'h0,        32'h02000002, 1'b0, 8'd1},  // R1 rev/class
    '{1'b0, 3'd0, 8'h2C, 2'd2, 32'h0,        32'h00015A17, 1'b0, 8'd1},  // R1 subsystem
    '{1'b0, 3'd0, 8'h3C, 2'd2, 32'h0,        32'h00000100, 1'b0, 8'd1},  // R1 int pin
    '{1'b0, 3'd0, 8'h04, 2'd2, 32'h0,        32'h00100000, 1'b0, 8'd10}, // R10 status bit
    '{1'b0, 3'd0, 8'h34, 2'd0, 32'h0,        32'h00000050, 1'b0, 8'd10}, // R10 head
    '{1'b0, 3'd0, 8'h50, 2'd1, 32'h0,        32'h00004001, 1'b0, 8'd10}, // R10 id/next
    '{1'b0, 3'd0, 8'h40, 2'd1, 32'h0,        32'h00000005, 1'b0, 8'd10}, // R10 list end
    '{1'b1, 3'd0, 8'h04, 2'd1, 32'h0000FFFF, 32'h0,        1'b1, 8'd2},  // R2 cmd
    '{1'b0, 3'd0, 8'h04, 2'd1, 32'h0,        32'h00000007, 1'b0, 8'd2},  // R2
    '{1'b1, 3'd0, 8'h04, 2'd0, 32'h00000004, 32'h0,        1'b1, 8'd9},  // R9 enables flip
    '{1'b1, 3'd0, 8'h04, 2'd0, 32'h00000000, 32'h0,        1'b0, 8'd9},  // R9 master only
    '{1'b0, 3'd0, 8'h04, 2'd0, 32'h0,        32'h00000000, 1'b0, 8'd9},
    '{1'b1, 3'd0, 8'h10, 2'd2, 32'hFFFFFFFF, 32'h0,        1'b1, 8'd6},  // R6 io bar
    '{1'b0, 3'd0, 8'h10, 2'd2, 32'h0,        32'hFFFFFF01, 1'b0, 8'd6},
    '{1'b1, 3'd0, 8'h10, 2'd2, 32'hFFFFFFFF, 32'h0,        1'b0, 8'd9},  // R9 same value
    '{1'b1, 3'd0, 8'h18, 2'd2, 32'h12345678, 32'h0,        1'b1, 8'd6},  // R6 mem bar
    '{1'b0, 3'd0, 8'h18, 2'd2, 32'h0,        32'h12345000, 1'b0, 8'd6},
    '{1'b1, 3'd0, 8'h14, 2'd2, 32'hFFFFFFFF, 32'h0,        1'b0, 8'd6},  // R6 unimplemented
    '{1'b0, 3'd0, 8'h14, 2'd2, 32'h0,        32'h00000000, 1'b0, 8'd6},
    '{1'b1, 3'd0, 8'h0C, 2'd0, 32'h000000A5, 32'h0,        1'b0, 8'd5},  // R5
    '{1'b0, 3'd0, 8'h0C, 2'd0, 32'h0,        32'h000000A5, 1'b0, 8'd5},
    '{1'b1, 3'd0, 8'h3C, 2'd0, 32'h0000000B, 32'h0,        1'b0, 8'd5},  // R5
    '{1'b0, 3'd0, 8'h3C, 2'd1, 32'h0,        32'h0000010B, 1'b0, 8'd5},
    '{1'b1, 3'd0, 8'h00, 2'd2, 32'hFFFFFFFF, 32'h0,        1'b0, 8'd2},  // R2 ids fixed
    '{1'b0, 3'd0, 8'h00, 2'd2, 32'h0,        32'h0C3E5A17, 1'b0, 8'd2},
    '{1'b1, 3'd0, 8'h60, 2'd2, 32'hDEADBEEF, 32'h0,        1'b0, 8'd3},  // R3
    '{1'b0, 3'd0, 8'h60, 2'd0, 32'h0,        32'h000000EF, 1'b0, 8'd3},
    '{1'b0, 3'd0, 8'h61, 2'd1, 32'h0,        32'h0000ADBE, 1'b0, 8'd3},
    '{1'b1, 3'd0, 8'h50, 2'd1, 32'h0000FFFF, 32'h0,        1'b0, 8'd10}, // R10 caps fixed
    '{1'b0, 3'd0, 8'h50, 2'd1, 32'h0,        32'h00004001, 1'b0, 8'd10},
    '{1'b1, 3'd0, 8'hFC, 2'd2, 32'h99887766, 32'h0,        1'b0, 8'd5},
    '{1'b1, 3'd0, 8'hFE, 2'd2, 32'h44332211, 32'h0,        1'b0, 8'd4},  // R4 top edge
    '{1'b0, 3'd0, 8'hFC, 2'd2, 32'h0,        32'h22117766, 1'b0, 8'd4},
    '{1'b0, 3'd0, 8'h00, 2'd0, 32'h0,        32'h00000017, 1'b0, 8'd4},
    '{1'b0, 3'd0, 8'hFD, 2'd2, 32'h0,        32'h00000077, 1'b0, 8'd7},  // R7 fallback
    '{1'b0, 3'd0, 8'hFF, 2'd1, 32'h0,        32'h00000022, 1'b0, 8'd7},  // R7 fallback
    '{1'b0, 3'd0, 8'hFE, 2'd1, 32'h0,        32'h00002211, 1'b0, 8'd7},  // R7 legal
    '{1'b0, 3'd3, 8'h00, 2'd2, 32'h0,        32'hFFFFFFFF, 1'b0, 8'd8},  // R8
    '{1'b0, 3'd3, 8'h00, 2'd1, 32'h0,        32'h0000FFFF, 1'b0, 8'd8},
    '{1'b0, 3'd3, 8'h00, 2'd0, 32'h0,        32'h000000FF, 1'b0, 8'd8},
    '{1'b1, 3'd3, 8'h0C, 2'd0, 32'h00000011, 32'h0,        1'b0, 8'd8},
    '{1'b0, 3'd0, 8'h0C, 2'd0, 32'h0,        32'h000000A5, 1'b0, 8'd8},
    '{1'b1, 3'd3, 8'h04, 2'd0, 32'h00000003, 32'h0,        1'b0, 8'd8},
    '{1'b0, 3'd0, 8'h04, 2'd0, 32'h0,        32'h00000000, 1'b0, 8'd8},
    '{1'b1, 3'd0, 8'h19, 2'd0, 32'h000000FF, 32'h0,        1'b1, 8'd6},  // R6 byte lane
    '{1'b0, 3'd0, 8'h18, 2'd2, 32'h0,        32'h1234F000, 1'b0, 8'd6},
    '{1'b1, 3'd0, 8'h48, 2'd0, 32'h0000005C, 32'h0,        1'b0, 8'd5},  // R5 free area
    '{1'b0, 3'd0, 8'h48, 2'd0, 32'h0,        32'h0000005C, 1'b0, 8'd5}
  };

  task automatic chk(input int req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      failed++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic doReq(input logic wr, input logic [2:0] fn, input logic [7:0] ad,
                       input logic [1:0] sz, input logic [31:0] wd);
    @(negedge clk);
    reqValid = 1'b1;
    reqWrite = wr;
    reqFunc  = fn;
    reqAddr  = ad;
    reqSize  = sz;
    reqWdata = wd;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    reqWrite = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      failed++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state at the ports
    chk(1, "rspValid at reset", {31'h0, rspValid}, 32'h0);
    chk(1, "remap at reset", {31'h0, remapPulse}, 32'h0);
    chk(1, "cmd at reset", {16'h0, cmdOut}, 32'h0);
    chk(1, "bar0 at reset", barOut[31:0], 32'h00000001);
    chk(1, "bar2 at reset", barOut[95:64], 32'h0);

    for (int i = 0; i < NV; i++) begin
      doReq(VEC[i].wr, VEC[i].fn, VEC[i].addr, VEC[i].sz, VEC[i].wd);
      if (VEC[i].wr) begin
        chk(11, $sformatf("vec %0d rspValid", i), {31'h0, rspValid}, 32'h0);
        chk(int'(VEC[i].req), $sformatf("vec %0d remap", i), {31'h0, remapPulse},
            {31'h0, VEC[i].remap});
      end else begin
        chk(11, $sformatf("vec %0d rspValid", i), {31'h0, rspValid}, 32'h1);
        chk(int'(VEC[i].req), $sformatf("vec %0d data", i), rspData, VEC[i].exp);
        chk(9, $sformatf("vec %0d remap on read", i), {31'h0, remapPulse}, 32'h0);
      end
    end

    // R6 output port view of the bars written by the table
    chk(6, "bar0 port", barOut[31:0], 32'hFFFFFF01);
    chk(6, "bar2 port", barOut[95:64], 32'h1234F000);

    // R11 idle cycle after a read drops the valid flag
    doReq(1'b0, 3'd0, 8'h00, 2'd0, 32'h0);
    @(negedge clk);
    chk(11, "rspValid idle", {31'h0, rspValid}, 32'h0);

    // R9 pulse lasts one cycle
    doReq(1'b1, 3'd0, 8'h04, 2'd0, 32'h00000003);
    chk(9, "remap on enable write", {31'h0, remapPulse}, 32'h1);
    chk(2, "cmd port", {16'h0, cmdOut}, 32'h00000003);
    @(negedge clk);
    chk(9, "remap drops", {31'h0, remapPulse}, 32'h0);

    // R1 reset mid-run restores contents
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(1, "cmd after reset", {16'h0, cmdOut}, 32'h0);
    chk(1, "bar0 after reset", barOut[31:0], 32'h00000001);
    chk(1, "bar2 after reset", barOut[95:64], 32'h0);
    doReq(1'b0, 3'd0, 8'h0C, 2'd0, 32'h0);
    chk(1, "line size after reset", rspData, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

endmodule